// File: doc/BRIEF.md
# Programmable Transmit Word Packer

This block sits between a 32-bit transmit FIFO and a serial shifter. It takes one FIFO entry at a time and cuts it into short bit chunks (one to eight bits each) under the control of four programmable packing vectors. It then joins the chunks into protocol words of a programmable size, from 4 to 32 bits. Each vector names a start bit, a walking direction, a chunk length and a stop flag. Used together, the vectors describe layouts such as four 7-bit words sent most significant bit first, two 15-bit words sent least significant bit first, or one 23-bit word per entry.

FIFO entries arrive on a valid/ready input. Protocol words leave on a valid/ready output that holds its word until it is taken. Three configuration registers are written through a simple write port. Written values wait in shadow copies and become active only when the next FIFO entry is accepted, so one entry is always packed under a single configuration.

Top module: `tx_word_packer`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1. The active configuration is four vectors, each taking 8 bits upward, starting at bits 0, 8, 16 and 24, with the stop flag only on the fourth vector. Word size is 8 and granularity is 0, so each entry leaves as four bytes, lowest byte first.
- R2: A vector is 10 bits: start index in [9:5], direction in [4], length minus one in [3:1], stop in [0]. Address 0 holds vector 0 in bits [9:0] and vector 1 in bits [19:10]. Address 1 holds vectors 2 and 3 in the same positions. Address 2 holds word size in [5:0] and granularity in [7:6]. Bits [31:20] of addresses 0 and 1, and any write to address 3, have no effect.
- R3: A vector takes n = length field + 1 bits. With direction 0 it takes bits start to start+n-1, and the start bit becomes the least significant bit of the chunk. With direction 1 it takes bits start down to start-n+1, and the start bit becomes the most significant bit of the chunk. Positions outside 0..31 read as zero.
- R4: A direction-0 chunk is placed above the bits already gathered. A direction-1 chunk shifts the gathered bits up and fills in below them. Once the gathered count reaches the effective word size, the low word-size bits are emitted, any excess bits are dropped, and gathering restarts from empty. A partial word carries over into the next entry.
- R5: The effective word size is the programmed size raised to at least 4, then capped at 8, 16 or 32 for granularity 0, 1 or 2. Granularity 3 acts as 2.
- R6: Vectors are applied in order 0 to 3, one per clock. The first vector with its stop flag set is the last one for the entry, and the vectors after it are ignored. If no stop flag is set, vector 3 ends the entry.
- R7: While `out_valid` is high and `out_ready` is low, `out_word` holds still. Under any pattern of `out_ready`, every word is delivered exactly once and in order.
- R8: Only one entry is held at a time. `in_ready` is high exactly when no entry is held, and it drops in the cycle after an entry is accepted.
- R9: A configuration write reaches the packing logic only when the next entry is accepted. An entry that is already held finishes under the configuration it started with.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | FIFO entry offered |
| in_ready | output | 1 | Packer can take an entry |
| in_data | input | 32 | FIFO entry |
| out_valid | output | 1 | Protocol word available |
| out_ready | input | 1 | Consumer takes the word |
| out_word | output | 32 | Protocol word, right aligned |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration register select |
| cfg_wdata | input | 32 | Configuration write data |

## Verification
The bench sweeps every start index in both directions with a single stop-flagged vector. This exposes an off-by-one in the bit window or in the zero fill near bits 0 and 31; a design with either fault would shift or corrupt bytes. Worked layouts check chunk order when words are joined. A swapped join order would send a 23-bit or 15-bit word with its bytes reversed. A missed stop flag would emit an extra word from the vector after it. Boundary sizes (below 4, above the granularity cap, over 32) and an overfull gather catch faulty clamping, which would produce words that are too wide or too narrow. Random back-pressure and a configuration rewrite during a held entry expose lost or duplicated words and an entry split across two configurations.

// File: rtl/tx_pack_pkg.sv
package tx_pack_pkg;

    localparam int ENTRY_W = 32;
    localparam int NVEC    = 4;
    localparam int CHUNK_W = 8;
    localparam int START_W = $clog2(ENTRY_W);
    localparam int VIDX_W  = $clog2(NVEC);
    localparam int SIZE_W  = $clog2(ENTRY_W) + 1;
    localparam int NLEN_W  = $clog2(CHUNK_W) + 1;
    localparam int CFG_AW  = 2;
    localparam int SIZE_ADDR = NVEC / 2;
    localparam int VEC_W   = START_W + 1 + $clog2(CHUNK_W) + 1;

    typedef struct packed {
        logic [START_W-1:0]         start;
        logic                       down;
        logic [$clog2(CHUNK_W)-1:0] len_m1;
        logic                       stop;
    } pack_vec_t;

    function automatic pack_vec_t reset_vec(input int idx);
        pack_vec_t v;
        v.start  = START_W'(CHUNK_W * idx);
        v.down   = 1'b0;
        v.len_m1 = '1;
        v.stop   = (idx == NVEC - 1);
        return v;
    endfunction

    function automatic logic [ENTRY_W-1:0] size_mask(input logic [SIZE_W-1:0] w);
        logic [ENTRY_W:0] m;
        m = ({{ENTRY_W{1'b0}}, 1'b1} << w) - 1'b1;
        return m[ENTRY_W-1:0];
    endfunction

endpackage

// File: rtl/tx_pack_cfg.sv
module tx_pack_cfg
    import tx_pack_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       we,
    input  logic [CFG_AW-1:0]          addr,
    input  logic [ENTRY_W-1:0]         wdata,
    input  logic                       load,
    output pack_vec_t [NVEC-1:0]       act_vec,
    output logic [SIZE_W-1:0]          eff_size
);

    typedef struct packed {
        pack_vec_t [NVEC-1:0] sh_vec;
        logic [SIZE_W-1:0]    sh_size;
        logic [1:0]           sh_gran;
        pack_vec_t [NVEC-1:0] ac_vec;
        logic [SIZE_W-1:0]    ac_size;
        logic [1:0]           ac_gran;
    } cfg_state_t;

    cfg_state_t s_q, s_d;
    cfg_state_t s_rst;

    always_comb begin
        s_rst = '0;
        for (int i = 0; i < NVEC; i++) begin
            s_rst.sh_vec[i] = reset_vec(i);
            s_rst.ac_vec[i] = reset_vec(i);
        end
        s_rst.sh_size = SIZE_W'(CHUNK_W);
        s_rst.ac_size = SIZE_W'(CHUNK_W);
    end

    always_comb begin
        s_d = s_q;
        if (we) begin
            for (int a = 0; a < SIZE_ADDR; a++) begin
                if (addr == CFG_AW'(a)) begin
                    s_d.sh_vec[2*a]   = wdata[VEC_W-1:0];
                    s_d.sh_vec[2*a+1] = wdata[2*VEC_W-1:VEC_W];
                end
            end
            if (addr == CFG_AW'(SIZE_ADDR)) begin
                s_d.sh_size = wdata[SIZE_W-1:0];
                s_d.sh_gran = wdata[SIZE_W+1:SIZE_W];
            end
        end
        if (load) begin
            s_d.ac_vec  = s_q.sh_vec;
            s_d.ac_size = s_q.sh_size;
            s_d.ac_gran = s_q.sh_gran;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= s_rst;
        else        s_q <= s_d;
    end

    logic [SIZE_W-1:0] floor_size;
    logic [SIZE_W-1:0] cap_size;

    always_comb begin
        floor_size = (s_q.ac_size < SIZE_W'(4)) ? SIZE_W'(4) : s_q.ac_size;
        case (s_q.ac_gran)
            2'd0:    cap_size = SIZE_W'(CHUNK_W);
            2'd1:    cap_size = SIZE_W'(2 * CHUNK_W);
            default: cap_size = SIZE_W'(ENTRY_W);
        endcase
        eff_size = (floor_size > cap_size) ? cap_size : floor_size;
    end

    assign act_vec = s_q.ac_vec;

endmodule

// File: rtl/tx_pack_chunk.sv
module tx_pack_chunk
    import tx_pack_pkg::*;
(
    input  logic [ENTRY_W-1:0] entry,
    input  pack_vec_t          vec,
    output logic [CHUNK_W-1:0] chunk,
    output logic [NLEN_W-1:0]  nbits
);

    localparam int EXT_W = ENTRY_W + CHUNK_W;
    localparam int SH_W  = $clog2(EXT_W + 2);

    logic [EXT_W-1:0]   ext;
    logic [EXT_W-1:0]   shifted;
    logic [SH_W-1:0]    sh;
    logic [CHUNK_W:0]   lmask;

    always_comb begin
        nbits = {1'b0, vec.len_m1} + NLEN_W'(1);
        ext   = {entry, {CHUNK_W{1'b0}}};
        if (vec.down)
            sh = SH_W'(vec.start) + SH_W'(CHUNK_W + 1) - SH_W'(nbits);
        else
            sh = SH_W'(vec.start) + SH_W'(CHUNK_W);
        shifted = ext >> sh;
        lmask   = ({{CHUNK_W{1'b0}}, 1'b1} << nbits) - 1'b1;
        chunk   = shifted[CHUNK_W-1:0] & lmask[CHUNK_W-1:0];
    end

endmodule

// File: rtl/tx_word_packer.sv
module tx_word_packer
    import tx_pack_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [31:0]        in_data,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [31:0]        out_word,
    input  logic               cfg_we,
    input  logic [1:0]         cfg_addr,
    input  logic [31:0]        cfg_wdata
);

    typedef struct packed {
        logic [ENTRY_W-1:0] ent;
        logic               ent_vld;
        logic [VIDX_W-1:0]  vidx;
        logic [ENTRY_W-1:0] acc;
        logic [SIZE_W-1:0]  acc_len;
        logic               ov;
        logic [ENTRY_W-1:0] ow;
    } pk_state_t;

    pk_state_t s_q, s_d;

    pack_vec_t [NVEC-1:0] act_vec;
    logic [SIZE_W-1:0]    eff_size;
    logic                 accept;
    pack_vec_t            cur_vec;
    logic [CHUNK_W-1:0]   chunk;
    logic [NLEN_W-1:0]    nbits;

    assign in_ready = !s_q.ent_vld;
    assign accept   = in_valid && in_ready;
    assign cur_vec  = act_vec[s_q.vidx];

    tx_pack_cfg u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (cfg_we),
        .addr     (cfg_addr),
        .wdata    (cfg_wdata),
        .load     (accept),
        .act_vec  (act_vec),
        .eff_size (eff_size)
    );

    tx_pack_chunk u_chunk (
        .entry (s_q.ent),
        .vec   (cur_vec),
        .chunk (chunk),
        .nbits (nbits)
    );

    logic               step;
    logic               emit;
    logic               last_vec;
    logic [SIZE_W:0]    new_len;
    logic [ENTRY_W-1:0] acc_new;
    logic [ENTRY_W-1:0] chunk_ext;

    always_comb begin
        s_d       = s_q;
        chunk_ext = ENTRY_W'(chunk);
        step      = s_q.ent_vld && (!s_q.ov || out_ready);
        new_len   = {1'b0, s_q.acc_len} + (SIZE_W + 1)'(nbits);
        if (cur_vec.down)
            acc_new = (s_q.acc << nbits) | chunk_ext;
        else
            acc_new = s_q.acc | (chunk_ext << s_q.acc_len);
        emit     = new_len >= {1'b0, eff_size};
        last_vec = cur_vec.stop || (s_q.vidx == VIDX_W'(NVEC - 1));

        if (s_q.ov && out_ready)
            s_d.ov = 1'b0;

        if (step) begin
            if (emit) begin
                s_d.ov      = 1'b1;
                s_d.ow      = acc_new & size_mask(eff_size);
                s_d.acc     = '0;
                s_d.acc_len = '0;
            end else begin
                s_d.acc     = acc_new;
                s_d.acc_len = new_len[SIZE_W-1:0];
            end
            if (last_vec) begin
                s_d.ent_vld = 1'b0;
                s_d.vidx    = '0;
            end else begin
                s_d.vidx = s_q.vidx + 1'b1;
            end
        end

        if (accept) begin
            s_d.ent     = in_data;
            s_d.ent_vld = 1'b1;
            s_d.vidx    = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign out_valid = s_q.ov;
    assign out_word  = s_q.ow;

endmodule

// File: rtl/tx_word_packer_chk.sv
module tx_word_packer_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic        in_ready,
    input logic        out_valid,
    input logic        out_ready,
    input logic [31:0] out_word,
    input logic [5:0]  eff_size
);

    // R7: a pending word holds until taken
    p_out_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_word));

    // R8: an accepted entry blocks further acceptance next cycle
    p_busy_after_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> !in_ready);

    // R8: a word can only appear while an entry was held
    p_word_needs_entry_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> $past(!in_ready));

    // R4 and R5: a fresh word carries no bits above the effective size
    p_word_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && (!$past(out_valid) || $past(out_ready)) && (eff_size < 6'd32)
        |-> ((out_word >> eff_size) == 32'd0));

endmodule

bind tx_word_packer tx_word_packer_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_word  (out_word),
    .eff_size  (eff_size)
);

// File: tb/tx_word_packer_test.sv
module tx_word_packer_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic        in_ready;
    logic [31:0] in_data;
    logic        out_valid;
    logic        out_ready;
    logic [31:0] out_word;
    logic        cfg_we;
    logic [1:0]  cfg_addr;
    logic [31:0] cfg_wdata;

    always #(CLK_PERIOD/2) clk = ~clk;

    tx_word_packer uut (
        .clk (clk), .rst_n (rst_n),
        .in_valid (in_valid), .in_ready (in_ready), .in_data (in_data),
        .out_valid (out_valid), .out_ready (out_ready), .out_word (out_word),
        .cfg_we (cfg_we), .cfg_addr (cfg_addr), .cfg_wdata (cfg_wdata)
    );

    int total = 0;
    int bad   = 0;
    int wd    = 0;
    logic [15:0] lfsr = 16'hACE1;

    logic [31:0] ent_a [8];
    int          n_ent;
    logic [31:0] exp_w [64];
    int          n_exp;
    logic [31:0] ca [3];
    logic [31:0] cb [3];
    int          switch_at;

    always @(posedge clk) begin
        wd++;
        if (wd > 150000) begin
            bad++;
            $display("FAIL watchdog expired act=%0d exp=<150000", wd);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", what, act, expv);
        end
    endtask

    function automatic logic [9:0] vec(input int st, input int dn, input int lf, input int sp);
        return {st[4:0], dn[0], lf[2:0], sp[0]};
    endfunction

    function automatic logic [31:0] pair(input logic [9:0] a, input logic [9:0] b);
        return {12'd0, b, a};
    endfunction

    task automatic build_expect();
        logic [31:0] acc;
        int alen;
        acc = 0; alen = 0; n_exp = 0;
        for (int i = 0; i < n_ent; i++) begin
            logic [31:0] r0, r1, r2;
            int ws, g, cap, w;
            r0 = (i >= switch_at) ? cb[0] : ca[0];
            r1 = (i >= switch_at) ? cb[1] : ca[1];
            r2 = (i >= switch_at) ? cb[2] : ca[2];
            ws = int'(r2[5:0]); g = int'(r2[7:6]);
            cap = (g == 0) ? 8 : (g == 1) ? 16 : 32;
            w = (ws < 4) ? 4 : ws;
            if (w > cap) w = cap;
            for (int v = 0; v < 4; v++) begin
                logic [9:0] vv;
                logic [31:0] ch;
                int st, dn, n;
                vv = (v < 2) ? 10'(r0 >> (10*v)) : 10'(r1 >> (10*(v-2)));
                st = int'(vv[9:5]); dn = int'(vv[4]); n = int'(vv[3:1]) + 1;
                ch = 0;
                for (int k = 0; k < n; k++) begin
                    int p;
                    logic b;
                    p = dn ? st - k : st + k;
                    b = (p >= 0 && p < 32) ? ent_a[i][p] : 1'b0;
                    if (dn) ch[n-1-k] = b; else ch[k] = b;
                end
                if (dn) acc = (acc << n) | ch;
                else    acc = acc | (ch << alen);
                alen += n;
                if (alen >= w) begin
                    exp_w[n_exp] = (w == 32) ? acc : (acc & ((32'd1 << w) - 1));
                    n_exp++;
                    acc = 0; alen = 0;
                end
                if (vv[0]) break;
            end
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; in_valid = 0; in_data = 0; out_ready = 0;
        cfg_we = 0; cfg_addr = 0; cfg_wdata = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 0;
    endtask

    task automatic load_a();
        wr(2'd0, ca[0]); wr(2'd1, ca[1]); wr(2'd2, ca[2]);
    endtask

    task automatic run_case(input string tag, input int mode, input bit midwr);
        int ei, oi, cyc, extra;
        build_expect();
        ei = 0; oi = 0; cyc = 0;
        while ((ei < n_ent || oi < n_exp) && cyc < 3000) begin
            @(negedge clk);
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            in_valid  = (ei < n_ent);
            in_data   = ent_a[(ei < 8) ? ei : 0];
            out_ready = (mode == 0) ? 1'b1 : (mode == 1) ? lfsr[0] : ((cyc >= 12) ? lfsr[0] : 1'b0);
            if (midwr && cyc >= 3 && cyc <= 5) begin
                cfg_we = 1; cfg_addr = 2'(cyc - 3); cfg_wdata = cb[cyc - 3];
            end else begin
                cfg_we = 0;
            end
            #1;
            if (midwr && cyc == 1)
                chk(in_ready == 1'b0, "R8 in_ready low while entry held", 32'(in_ready), 32'd0);
            if (in_valid && in_ready) ei++;
            if (out_valid && out_ready) begin
                if (oi < n_exp)
                    chk(out_word == exp_w[oi], tag, out_word, exp_w[oi]);
                else
                    chk(1'b0, "R7 word beyond expected", out_word, 32'd0);
                oi++;
            end
            cyc++;
        end
        in_valid = 0; cfg_we = 0;
        chk(oi == n_exp && ei == n_ent, "R7 every word delivered", 32'(oi), 32'(n_exp));
        extra = 0;
        repeat (6) begin
            @(negedge clk);
            out_ready = 1; #1;
            if (out_valid) extra++;
        end
        chk(extra == 0, "R6 R7 no extra word after stream", 32'(extra), 32'd0);
    endtask

    task automatic set_entries();
        ent_a[0] = 32'hA5C3_7E19; ent_a[1] = 32'h1234_5678;
        ent_a[2] = 32'hFFFF_0001; ent_a[3] = 32'h8000_00FE;
        n_ent = 4; switch_at = 99;
    endtask

    initial begin
        logic [31:0] dflt [3];
        dflt[0] = pair(vec(0,0,7,0), vec(8,0,7,0));
        dflt[1] = pair(vec(16,0,7,0), vec(24,0,7,1));
        dflt[2] = 32'd8;

        do_reset();
        #1;
        chk(out_valid == 1'b0, "R1 out_valid after reset", 32'(out_valid), 32'd0);
        chk(in_ready == 1'b1, "R1 in_ready after reset", 32'(in_ready), 32'd1);

        // R1 reset configuration, with an address-3 write that must be ignored (R2)
        set_entries();
        ca = dflt;
        wr(2'd3, 32'hFFFF_FFFF);
        run_case("R1 R2 reset byte stream", 0, 0);

        // R3 downward chunks, 7-bit words
        do_reset(); set_entries();
        ca[0] = pair(vec(6,1,6,0), vec(14,1,6,0));
        ca[1] = pair(vec(22,1,6,0), vec(30,1,6,1));
        ca[2] = 32'd7;
        load_a();
        run_case("R3 seven bit msb first", 1, 0);

        // R4 upward join, 15-bit words, junk in unused upper bits (R2)
        do_reset(); set_entries();
        ca[0] = 32'hABC0_0000 | pair(vec(0,0,7,0), vec(8,0,6,0));
        ca[1] = 32'h5A50_0000 | pair(vec(16,0,7,0), vec(24,0,6,1));
        ca[2] = 32'd15 | (32'd1 << 6);
        load_a();
        run_case("R2 R4 fifteen bit lsb first", 1, 0);

        // R6 stop on vector 2, vector 3 must be ignored; R4 downward join
        do_reset(); set_entries();
        ca[0] = pair(vec(22,1,7,0), vec(14,1,7,0));
        ca[1] = pair(vec(6,1,6,1), vec(31,0,7,1));
        ca[2] = 32'd23 | (32'd2 << 6);
        load_a();
        run_case("R4 R6 twenty-three bit stop on vector 2", 1, 0);

        // R6 no stop flag at all: vector 3 ends the entry
        do_reset(); set_entries();
        ca[0] = pair(vec(0,0,7,0), vec(8,0,7,0));
        ca[1] = pair(vec(16,0,7,0), vec(24,0,7,0));
        ca[2] = 32'd8;
        load_a();
        run_case("R6 no stop flag", 0, 0);

        // R4 overfull gather drops excess bits
        do_reset(); set_entries();
        ca[0] = pair(vec(0,0,7,0), vec(8,0,7,0));
        ca[1] = pair(vec(16,0,7,0), vec(24,0,7,1));
        ca[2] = 32'd12 | (32'd2 << 6);
        load_a();
        run_case("R4 twelve bit word excess dropped", 1, 0);

        // R5 granularity cap: size 16 with granularity 0 gives 8
        do_reset(); set_entries();
        ca[0] = pair(vec(0,0,7,0), vec(8,0,7,0));
        ca[1] = pair(vec(16,0,7,0), vec(24,0,7,1));
        ca[2] = 32'd16;
        load_a();
        run_case("R5 size capped by granularity", 0, 0);

        // R5 floor: size 2 acts as 4
        do_reset(); set_entries();
        ca[0] = pair(vec(0,0,3,0), vec(4,0,3,0));
        ca[1] = pair(vec(8,0,3,0), vec(12,0,3,1));
        ca[2] = 32'd2 | (32'd2 << 6);
        load_a();
        run_case("R5 size raised to four", 1, 0);

        // R5 granularity 3 and size 40 act as 32
        do_reset(); set_entries();
        ca[0] = pair(vec(0,0,7,0), vec(8,0,7,0));
        ca[1] = pair(vec(16,0,7,0), vec(24,0,7,1));
        ca[2] = 32'd40 | (32'd3 << 6);
        load_a();
        run_case("R5 granularity 3 full word", 1, 0);

        // R3 sweep of every start index in both directions
        for (int s = 0; s < 32; s++) begin
            for (int d = 0; d < 2; d++) begin
                do_reset();
                ent_a[0] = 32'hC3A5_96E1 ^ (32'h0101_0101 * 32'(s));
                ent_a[1] = ~ent_a[0];
                n_ent = 2; switch_at = 99;
                ca[0] = pair(vec(s,d,7,1), 10'd0);
                ca[1] = 32'd0;
                ca[2] = 32'd8;
                load_a();
                run_case("R3 start index sweep", 0, 0);
            end
        end

        // R9 rewrite while an entry is held; R8 checked inside
        do_reset();
        ent_a[0] = 32'h7F3E_9D21; ent_a[1] = 32'h0C5B_E6A4;
        n_ent = 2; switch_at = 1;
        ca = dflt;
        cb[0] = pair(vec(6,1,6,0), vec(14,1,6,0));
        cb[1] = pair(vec(22,1,6,0), vec(30,1,6,1));
        cb[2] = 32'd7;
        run_case("R9 config applies at entry boundary", 2, 1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule